// File: doc/BRIEF.md
# Double-Precision Compare to Condition Flags

This block takes two IEEE-754 binary64 operands and a current condition-flag word. It returns an updated flag word that encodes the ordering of the pair. The pair falls into one of four classes: unordered (at least one operand is a NaN), less, equal or greater. The zero, parity and carry flags carry the class. The overflow, sign and auxiliary-carry flags are always cleared, and every other bit of the flag word passes through unchanged.

The block has one pipeline register. When `in_valid` is asserted, the operands and the flag word are sampled, and the result appears with `out_valid` on the next clock. Flag bit positions follow the common layout: carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. The block does no arithmetic, raises no exceptions and treats signalling and quiet NaNs the same way.

Top module: `fcmp_flags`

## Requirements
- R1: If either operand is a NaN (exponent field bits 62:52 all ones and fraction bits 51:0 nonzero), the result has zero (bit 6), parity (bit 2) and carry (bit 0) all set.
- R2: If both operands are ordered and the first is greater than the second, zero, parity and carry are all 0.
- R3: If both operands are ordered and the first is less than the second, carry is 1 and zero and parity are 0.
- R4: If both operands are ordered and equal, zero is 1 and parity and carry are 0. Positive zero and negative zero count as equal.
- R5: Overflow (bit 11), sign (bit 7) and auxiliary carry (bit 4) are 0 in every result.
- R6: Every flag bit other than bits 0, 2, 4, 6, 7 and 11 equals the corresponding bit of the input flag word.
- R7: Non-NaN values are ordered by sign and magnitude. Of two negative values, the one with the larger magnitude is smaller. Infinities order as the extreme values.
- R8: `out_valid` is high exactly one cycle after `in_valid` is high, and `out_flags` holds its previous value while no new input is accepted.
- R9: After a synchronous reset, `out_valid` is 0 and `out_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and flags are presented this cycle |
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| flags_in | input | 64 | Current flag word |
| out_valid | output | 1 | Result is valid this cycle |
| out_flags | output | 64 | Updated flag word |

## Verification
The bench targets the following corner cases, and each one exposes a specific kind of bug:
- **Signed zeros.** A design that compares raw bit patterns would report +0 and -0 as unequal.
- **Negative pairs.** A design that compares magnitudes alone would get the ordering of two negative values backwards.
- **Infinity against NaN.** Infinity shares the all-ones exponent with NaN, so a design that ignores the fraction would call infinity unordered.
- **NaN with only a low fraction bit set.** This shows whether the design tests every fraction bit.

Flag words with random content catch a design that clears too much or too little. Gaps in `in_valid` catch a result register that updates without new input.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FLAG_W = 64;

    localparam int BIT_CARRY = 0;
    localparam int BIT_PAR   = 2;
    localparam int BIT_AUX   = 4;
    localparam int BIT_ZERO  = 6;
    localparam int BIT_SIGN  = 7;
    localparam int BIT_OVF   = 11;

    typedef enum logic [1:0] {
        CMP_GT  = 2'd0,
        CMP_LT  = 2'd1,
        CMP_EQ  = 2'd2,
        CMP_UNO = 2'd3
    } cmp_class_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    function automatic logic is_nan(fp_t v);
        return (&v.expo) && (|v.frac);
    endfunction

    function automatic logic is_zero(fp_t v);
        return (v.expo == '0) && (v.frac == '0);
    endfunction

    function automatic logic [FLAG_W-1:0] touched_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        m[BIT_CARRY] = 1'b1;
        m[BIT_PAR]   = 1'b1;
        m[BIT_AUX]   = 1'b1;
        m[BIT_ZERO]  = 1'b1;
        m[BIT_SIGN]  = 1'b1;
        m[BIT_OVF]   = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  fp_t        a,
    input  fp_t        b,
    output cmp_class_e cls
);
    logic [FP_W-2:0] mag_a, mag_b;
    logic a_nan, b_nan, both_zero, mag_lt, mag_eq;

    always_comb begin
        mag_a     = {a.expo, a.frac};
        mag_b     = {b.expo, b.frac};
        a_nan     = is_nan(a);
        b_nan     = is_nan(b);
        both_zero = is_zero(a) && is_zero(b);
        mag_lt    = mag_a < mag_b;
        mag_eq    = mag_a == mag_b;
        if (a_nan || b_nan)
            cls = CMP_UNO;
        else if (both_zero || (mag_eq && a.sign == b.sign))
            cls = CMP_EQ;
        else if (a.sign != b.sign)
            cls = a.sign ? CMP_LT : CMP_GT;
        else if (!a.sign)
            cls = mag_lt ? CMP_LT : CMP_GT;
        else
            cls = mag_lt ? CMP_GT : CMP_LT;
    end
endmodule

// File: rtl/fcmp_flag_merge.sv
module fcmp_flag_merge
    import fcmp_pkg::*;
(
    input  cmp_class_e        cls,
    input  logic [FLAG_W-1:0] old_flags,
    output logic [FLAG_W-1:0] new_flags
);
    localparam logic [FLAG_W-1:0] KEEP = ~touched_mask();

    always_comb begin
        new_flags = old_flags & KEEP;
        unique case (cls)
            CMP_UNO: begin
                new_flags[BIT_ZERO]  = 1'b1;
                new_flags[BIT_PAR]   = 1'b1;
                new_flags[BIT_CARRY] = 1'b1;
            end
            CMP_LT:  new_flags[BIT_CARRY] = 1'b1;
            CMP_EQ:  new_flags[BIT_ZERO]  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   op_a,
    input  logic [FP_W-1:0]   op_b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [FLAG_W-1:0] out_flags
);
    cmp_class_e        cls;
    logic [FLAG_W-1:0] merged;

    fcmp_classify u_cls (
        .a   (fp_t'(op_a)),
        .b   (fp_t'(op_b)),
        .cls (cls)
    );

    fcmp_flag_merge u_merge (
        .cls       (cls),
        .old_flags (flags_in),
        .new_flags (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_flags <= merged;
        end
    end

    // Checks on the registered result
    assert_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_flags[BIT_OVF] && !out_flags[BIT_SIGN] && !out_flags[BIT_AUX]);

    assert_passthru_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_flags & ~touched_mask()) == ($past(flags_in) & ~touched_mask())));

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_flags) && !out_valid);

    assert_unordered_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (is_nan(fp_t'(op_a)) || is_nan(fp_t'(op_b))))
        |=> out_flags[BIT_ZERO] && out_flags[BIT_PAR] && out_flags[BIT_CARRY]);

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_flags[BIT_PAR] && !(out_flags[BIT_ZERO] && out_flags[BIT_CARRY])));

    assert_signed_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_zero(fp_t'(op_a)) && is_zero(fp_t'(op_b)))
        |=> out_flags[BIT_ZERO] && !out_flags[BIT_PAR] && !out_flags[BIT_CARRY]);
endmodule

// File: tb/fcmp_flags_tb_top.sv
module fcmp_flags_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] op_a, op_b, flags_in;
    logic        out_valid;
    logic [63:0] out_flags;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] exp_q[$];
    logic [63:0] last_exp;
    logic        exp_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_flags dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .flags_in(flags_in),
        .out_valid(out_valid), .out_flags(out_flags)
    );

    function automatic bit ref_nan(logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    // -1 less, 0 equal, 1 greater, 2 unordered
    function automatic int ref_order(logic [63:0] a, logic [63:0] b);
        longint ka, kb;
        if (ref_nan(a) || ref_nan(b)) return 2;
        // map to totally ordered signed keys; both zeros map to 0
        ka = a[63] ? -longint'({1'b0, a[62:0]}) : longint'({1'b0, a[62:0]});
        kb = b[63] ? -longint'({1'b0, b[62:0]}) : longint'({1'b0, b[62:0]});
        if (ka < kb) return -1;
        if (ka == kb) return 0;
        return 1;
    endfunction

    function automatic logic [63:0] ref_flags(logic [63:0] a, logic [63:0] b, logic [63:0] f);
        logic [63:0] r;
        int o;
        r = f;
        r[0] = 0; r[2] = 0; r[4] = 0; r[6] = 0; r[7] = 0; r[11] = 0;
        o = ref_order(a, b);
        if (o == 2) begin r[0] = 1; r[2] = 1; r[6] = 1; end
        else if (o == -1) r[0] = 1;
        else if (o == 0) r[6] = 1;
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Compare on every clock, at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R8 valid", {63'd0, out_valid}, {63'd0, exp_v});
            if (exp_v) check("R1-7 flags", out_flags, last_exp);
            else       check("R8 hold", out_flags, last_exp);
        end
    end

    task automatic drive(logic [63:0] a, logic [63:0] b, logic [63:0] f, logic v);
        in_valid = v; op_a = a; op_b = b; flags_in = f;
        @(posedge clk);
        #1;
        exp_v = v;
        if (v) last_exp = ref_flags(a, b, f);
    endtask

    localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] MONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] LNAN  = 64'hFFF0_0000_0000_0001;

    initial begin
        logic [63:0] rv;
        rst = 1; in_valid = 0; op_a = 0; op_b = 0; flags_in = 0;
        exp_v = 0; last_exp = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset valid", {63'd0, out_valid}, 64'd0);
        check("R9 reset flags", out_flags, 64'd0);
        rst = 0;
        drive(QNAN, ONE, 64'hFFFF_FFFF_FFFF_FFFF, 1);  // R1
        drive(ONE, LNAN, 64'h0, 1);                     // R1 low fraction bit
        drive(PINF, QNAN, 64'h0, 1);                    // R1
        drive(TWO, ONE, 64'hFFFF_FFFF_FFFF_FFFF, 1);    // R2
        drive(ONE, TWO, 64'h0000_0000_0000_0A95, 1);    // R3
        drive(ONE, ONE, 64'h0, 1);                      // R4
        drive(PZERO, NZERO, 64'h1234_5678_9ABC_DEF0, 1);// R4 signed zero
        drive(NZERO, PZERO, 64'h0, 1);                  // R4
        drive(MTWO, MONE, 64'h0, 0);                    // R8 gap
        drive(MTWO, MONE, 64'h0, 1);                    // R7 -2 < -1
        drive(MONE, MTWO, 64'h0, 1);                    // R7
        drive(NINF, MTWO, 64'h0, 1);                    // R7
        drive(PINF, TWO, 64'h0, 1);                     // R7 inf ordered
        drive(PINF, PINF, 64'h0, 1);                    // R4
        drive(MONE, ONE, 64'h0, 1);                     // R7
        drive(PZERO, MONE, 64'h0, 1);                   // R7
        for (int i = 0; i < 200; i++) begin
            rv = {$urandom, $urandom};
            drive({$urandom, $urandom}, (i % 5 == 0) ? rv : {$urandom, $urandom},
                  {$urandom, $urandom}, (i % 7) != 3);  // R5 R6
        end
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule